// File: doc/BRIEF.md
# Microcontroller reset sequencing controller

This block decides when a microcontroller core may leave reset. It holds the core in reset after a power-on, after a qualified brown-out and after a wake from sleep, until the power-up delay and then the oscillator stabilisation count have run out. The power-up delay is counted in ticks of a slow internal RC clock. The stabilisation count is counted in cycles of the main oscillator clock. A four-phase request/acknowledge handshake links the two clock domains. The supply comparator, the trip-level reference and the oscillator are outside the block. The block only forwards the configured trip level to the comparator.

The sequencer is a five-state machine in the RC domain. `S_PWRT` counts the power-up delay. `S_BROWN` holds reset while the supply is below trip. `S_OST_REQ` raises the stabilisation request and waits for the acknowledge. `S_OST_REL` drops the request and waits for the acknowledge to clear. `S_RUN` releases the core. The transitions are:
- power-on → `S_PWRT`;
- `S_PWRT` → `S_OST_REQ` (crystal mode) or `S_RUN` (RC mode) when the delay ends or is bypassed;
- any state except `S_BROWN` → `S_BROWN` on a qualified brown-out;
- `S_BROWN` → `S_PWRT` when the supply recovers;
- `S_OST_REQ` → `S_OST_REL` on acknowledge;
- `S_OST_REL` → `S_RUN` when the acknowledge clears;
- `S_RUN` → `S_OST_REQ` on a wake request in a crystal mode.

The external reset pin acts alongside the state machine. It forces reset at once and never restarts either timer.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_pulse` is high, `dev_rst` is 1 and both `stat_npor` and `stat_bor` are 0.
- R2: After power-on with `cfg_pwrt_en`=1, `dev_rst` stays high for exactly PWRT_TICKS rising edges of `clk_rc` (RC mode). With `cfg_pwrt_en`=0 the delay is bypassed and release comes on the first edge.
- R3: In crystal modes (`cfg_osc_mode` 2'b00, 2'b01, 2'b10), release after the power-up stage is further delayed by at least OST_CYCLES cycles of `clk_osc`, plus handshake latency of no more than 16 RC ticks. In RC mode (2'b11) the stabilisation count is never run.
- R4: With `cfg_bor_en`=1, a brown-out is qualified only when the synchronised `bor_below` stays high for BOR_FILT_TICKS consecutive RC ticks. Shorter dips leave `dev_rst` low. With `cfg_bor_en`=0, `bor_below` never causes reset.
- R5: After a qualified brown-out, reset is held while `bor_below` stays high. When it falls, the full power-up delay runs whatever the value of `cfg_pwrt_en`.
- R6: A qualified brown-out during the power-up delay restarts that delay from zero after the supply recovers.
- R7: `bor_lvl_sel` always equals `cfg_bor_lvl`.
- R8: `stat_bor` is set when a brown-out is qualified. It is cleared by a `fw_clr_bor` pulse, and setting wins over clearing. `stat_npor` is set by a `fw_set_npor` pulse and is cleared only by power-on.
- R9: `mclr_n` low forces `dev_rst` high immediately with no clock edge. After release, `dev_rst` falls on the second `clk_rc` edge, without rerunning either timer.
- R10: A `wake_req` pulse in `S_RUN` holds reset during a fresh stabilisation count in crystal modes. In RC mode the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Slow internal RC tick clock |
| clk_osc | input | 1 | Main oscillator clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| bor_below | input | 1 | Comparator output, 1 = supply below trip level (asynchronous) |
| mclr_n | input | 1 | External master reset pin, active low (asynchronous) |
| wake_req | input | 1 | Wake-from-sleep request pulse, `clk_rc` domain |
| cfg_pwrt_en | input | 1 | Power-up delay enable for power-on resets |
| cfg_bor_en | input | 1 | Brown-out detection enable |
| cfg_bor_lvl | input | 2 | Trip level selection |
| cfg_osc_mode | input | 2 | 00 low-power crystal, 01 crystal, 10 high-speed crystal, 11 RC |
| fw_set_npor | input | 1 | Firmware write: set `stat_npor` |
| fw_clr_bor | input | 1 | Firmware write: clear `stat_bor` |
| dev_rst | output | 1 | Device reset, active high |
| stat_npor | output | 1 | 0 after a power-on until firmware sets it |
| stat_bor | output | 1 | Sticky brown-out cause flag |
| bor_lvl_sel | output | 2 | Trip level select to the comparator |

## Verification
The bench targets the following corner cases:
- A dip one tick shorter than the filter window. A filter that is off by one would reset the device on it.
- A brown-out after a power-on with the delay disabled. A design that applies the enable bit to brown-outs would release about three ticks after recovery instead of a full delay later.
- A second dip midway through the delay. A design that only pauses the counter would release early.
- A wake request in RC mode, which a careless decoder would turn into a spurious reset.
- Release of the external pin, which must not restart the delay.
- Flag priority and clearing.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        S_PWRT    = 3'd0,
        S_BROWN   = 3'd1,
        S_OST_REQ = 3'd2,
        S_OST_REL = 3'd3,
        S_RUN     = 3'd4
    } seq_state_e;

    localparam logic [1:0] OSC_LP = 2'b00;
    localparam logic [1:0] OSC_XT = 2'b01;
    localparam logic [1:0] OSC_HS = 2'b10;
    localparam logic [1:0] OSC_RC = 2'b11;

    // Crystal-type modes need the stabilisation count.
    function automatic logic osc_is_crystal(input logic [1:0] mode);
        return (mode == OSC_LP) || (mode == OSC_XT) || (mode == OSC_HS);
    endfunction

endpackage

// File: rtl/rst_seq_sync2.sv
module rst_seq_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);

    logic meta;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/rst_seq_bor_filter.sv
module rst_seq_bor_filter #(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic arst,
    input  logic enable,
    input  logic below,
    input  logic hold,
    output logic trip
);

    localparam int CW = $clog2(FILT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

    logic [CW-1:0] run_len;

    // Counts consecutive below-trip ticks; cleared by any gap.
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            run_len <= '0;
        end else if (!enable || !below || hold) begin
            run_len <= '0;
        end else if (run_len != LAST) begin
            run_len <= run_len + 1'b1;
        end
    end

    assign trip = enable && below && !hold && (run_len == LAST);

endmodule

// File: rtl/rst_seq_ost_timer.sv
module rst_seq_ost_timer #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk_osc,
    input  logic arst,
    input  logic req_rc,
    output logic ack
);

    localparam int CW = $clog2(OST_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    logic          req_s;
    logic [CW-1:0] cnt;

    rst_seq_sync2 #(.RST_VAL(1'b0)) req_sync_i (
        .clk  (clk_osc),
        .arst (arst),
        .d    (req_rc),
        .q    (req_s)
    );

    // Four-phase: count while request is high, hold ack until it drops.
    always_ff @(posedge clk_osc or posedge arst) begin
        if (arst) begin
            cnt <= '0;
            ack <= 1'b0;
        end else if (!req_s) begin
            cnt <= '0;
            ack <= 1'b0;
        end else if (!ack) begin
            if (cnt == LAST) begin
                ack <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS     = 72,
    parameter int OST_CYCLES     = 1024,
    parameter int BOR_FILT_TICKS = 4
) (
    input  logic       clk_rc,
    input  logic       clk_osc,
    input  logic       por_pulse,
    input  logic       bor_below,
    input  logic       mclr_n,
    input  logic       wake_req,
    input  logic       cfg_pwrt_en,
    input  logic       cfg_bor_en,
    input  logic [1:0] cfg_bor_lvl,
    input  logic [1:0] cfg_osc_mode,
    input  logic       fw_set_npor,
    input  logic       fw_clr_bor,
    output logic       dev_rst,
    output logic       stat_npor,
    output logic       stat_bor,
    output logic [1:0] bor_lvl_sel
);

    localparam int PCW = $clog2(PWRT_TICKS + 1);
    localparam logic [PCW-1:0] PWRT_LAST = PCW'(PWRT_TICKS - 1);

    seq_state_e     state_q, state_d;
    logic [PCW-1:0] pwrt_cnt_q, pwrt_cnt_d;
    logic           from_bor_q, from_bor_d;

    logic bor_s, mclr_s, ost_ack, ack_s, bor_trip;
    logic hold_rst, ost_req, in_brown, crystal, pwrt_skip;

    rst_seq_sync2 #(.RST_VAL(1'b0)) bor_sync_i (
        .clk (clk_rc), .arst (por_pulse), .d (bor_below), .q (bor_s)
    );

    rst_seq_sync2 #(.RST_VAL(1'b1)) mclr_sync_i (
        .clk (clk_rc), .arst (por_pulse), .d (mclr_n), .q (mclr_s)
    );

    rst_seq_sync2 #(.RST_VAL(1'b0)) ack_sync_i (
        .clk (clk_rc), .arst (por_pulse), .d (ost_ack), .q (ack_s)
    );

    rst_seq_bor_filter #(.FILT_TICKS(BOR_FILT_TICKS)) bor_filt_i (
        .clk    (clk_rc),
        .arst   (por_pulse),
        .enable (cfg_bor_en),
        .below  (bor_s),
        .hold   (in_brown),
        .trip   (bor_trip)
    );

    rst_seq_ost_timer #(.OST_CYCLES(OST_CYCLES)) ost_i (
        .clk_osc (clk_osc),
        .arst    (por_pulse),
        .req_rc  (ost_req),
        .ack     (ost_ack)
    );

    assign crystal   = osc_is_crystal(cfg_osc_mode);
    assign pwrt_skip = !from_bor_q && !cfg_pwrt_en;

    // State register
    always_ff @(posedge clk_rc or posedge por_pulse) begin
        if (por_pulse) begin
            state_q    <= S_PWRT;
            pwrt_cnt_q <= '0;
            from_bor_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            pwrt_cnt_q <= pwrt_cnt_d;
            from_bor_q <= from_bor_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        pwrt_cnt_d = pwrt_cnt_q;
        from_bor_d = from_bor_q;
        if (bor_trip) begin
            state_d    = S_BROWN;
            pwrt_cnt_d = '0;
            from_bor_d = 1'b1;
        end else begin
            unique case (state_q)
                S_PWRT: begin
                    if (pwrt_skip || (pwrt_cnt_q == PWRT_LAST)) begin
                        pwrt_cnt_d = '0;
                        state_d    = crystal ? S_OST_REQ : S_RUN;
                    end else begin
                        pwrt_cnt_d = pwrt_cnt_q + 1'b1;
                    end
                end
                S_BROWN: begin
                    if (!bor_s || !cfg_bor_en) begin
                        state_d = S_PWRT;
                    end
                end
                S_OST_REQ: begin
                    if (ack_s) begin
                        state_d = S_OST_REL;
                    end
                end
                S_OST_REL: begin
                    if (!ack_s) begin
                        state_d = S_RUN;
                    end
                end
                S_RUN: begin
                    if (wake_req && crystal) begin
                        state_d = S_OST_REQ;
                    end
                end
                default: begin
                    state_d    = S_PWRT;
                    pwrt_cnt_d = '0;
                end
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        hold_rst = (state_q != S_RUN);
        ost_req  = (state_q == S_OST_REQ);
        in_brown = (state_q == S_BROWN);
    end

    // Cause flags
    always_ff @(posedge clk_rc or posedge por_pulse) begin
        if (por_pulse) begin
            stat_npor <= 1'b0;
            stat_bor  <= 1'b0;
        end else begin
            if (fw_set_npor) begin
                stat_npor <= 1'b1;
            end
            if (bor_trip) begin
                stat_bor <= 1'b1;
            end else if (fw_clr_bor) begin
                stat_bor <= 1'b0;
            end
        end
    end

    assign dev_rst     = hold_rst || !mclr_n || !mclr_s;
    assign bor_lvl_sel = cfg_bor_lvl;

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk
    import rst_seq_pkg::*;
#(
    parameter int CW = 7
) (
    input logic          clk_rc,
    input logic          por_pulse,
    input seq_state_e    st,
    input logic [CW-1:0] pwrt_cnt,
    input logic          cfg_bor_en,
    input logic [1:0]    cfg_osc_mode,
    input logic          stat_bor
);

    // R4: with detection off, no brown-out is entered
    a_r4_off_no_brown: assert property (@(posedge clk_rc) disable iff (por_pulse)
        (!cfg_bor_en && st != S_BROWN) |=> (st != S_BROWN));

    // R8: entering brown-out sets the cause flag
    a_r8_flag_on_entry: assert property (@(posedge clk_rc) disable iff (por_pulse)
        (st != S_BROWN) ##1 (st == S_BROWN) |-> stat_bor);

    // R6: leaving brown-out restarts the delay at zero
    a_r6_restart_zero: assert property (@(posedge clk_rc) disable iff (por_pulse)
        (st == S_BROWN) |=> ((st == S_BROWN) || (st == S_PWRT && pwrt_cnt == '0)));

    // R5: recovery always passes through the power-up delay
    a_r5_delay_after_brown: assert property (@(posedge clk_rc) disable iff (por_pulse)
        (st == S_BROWN) ##1 (st != S_BROWN) |-> (st == S_PWRT));

    // R3: RC mode never requests the stabilisation count after the delay
    a_r3_rc_skips_ost: assert property (@(posedge clk_rc) disable iff (por_pulse)
        (st == S_PWRT && cfg_osc_mode == OSC_RC) |=> (st != S_OST_REQ));

    // R10: wake requests in RC mode do not leave run
    a_r10_rc_wake_ignored: assert property (@(posedge clk_rc) disable iff (por_pulse)
        (st == S_RUN && cfg_osc_mode == OSC_RC) |=> (st != S_OST_REQ));

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.CW(PCW)) chk_i (
    .clk_rc       (clk_rc),
    .por_pulse    (por_pulse),
    .st           (state_q),
    .pwrt_cnt     (pwrt_cnt_q),
    .cfg_bor_en   (cfg_bor_en),
    .cfg_osc_mode (cfg_osc_mode),
    .stat_bor     (stat_bor)
);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
    import rst_seq_pkg::*;

    localparam int P   = 20;
    localparam int OST = 16;
    localparam int F   = 3;
    localparam int SLK = 16;

    typedef struct packed {
        logic [1:0] mode;
        logic       pwrt_en;
        logic [1:0] lvl;
        int         lo;
        int         hi;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'b11, 1'b1, 2'd0, P,       P},
        '{2'b11, 1'b0, 2'd1, 1,       1},
        '{2'b00, 1'b1, 2'd2, P + OST, P + OST + SLK},
        '{2'b01, 1'b0, 2'd3, 1 + OST, 1 + OST + SLK},
        '{2'b10, 1'b1, 2'd1, P + OST, P + OST + SLK},
        '{2'b10, 1'b0, 2'd2, 1 + OST, 1 + OST + SLK},
        '{2'b01, 1'b1, 2'd0, P + OST, P + OST + SLK},
        '{2'b00, 1'b0, 2'd3, 1 + OST, 1 + OST + SLK}
    };

    logic clk_rc = 1'b0, clk_osc = 1'b0;
    logic por_pulse = 1'b1, bor_below = 1'b0, mclr_n = 1'b1, wake_req = 1'b0;
    logic cfg_pwrt_en = 1'b1, cfg_bor_en = 1'b1;
    logic [1:0] cfg_bor_lvl = 2'd0, cfg_osc_mode = OSC_RC;
    logic fw_set_npor = 1'b0, fw_clr_bor = 1'b0;
    logic dev_rst, stat_npor, stat_bor;
    logic [1:0] bor_lvl_sel;

    int n_chk = 0, n_bad = 0, wd = 0;

    always #2 clk_rc = ~clk_rc;
    initial begin
        #1;
        forever #2 clk_osc = ~clk_osc;
    end

    rst_seq_ctrl #(.PWRT_TICKS(P), .OST_CYCLES(OST), .BOR_FILT_TICKS(F)) dut_i (
        .clk_rc(clk_rc), .clk_osc(clk_osc), .por_pulse(por_pulse),
        .bor_below(bor_below), .mclr_n(mclr_n), .wake_req(wake_req),
        .cfg_pwrt_en(cfg_pwrt_en), .cfg_bor_en(cfg_bor_en),
        .cfg_bor_lvl(cfg_bor_lvl), .cfg_osc_mode(cfg_osc_mode),
        .fw_set_npor(fw_set_npor), .fw_clr_bor(fw_clr_bor),
        .dev_rst(dev_rst), .stat_npor(stat_npor), .stat_bor(stat_bor),
        .bor_lvl_sel(bor_lvl_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk_rc);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wait_release(output int n);
        n = 0;
        do begin
            @(negedge clk_rc);
            n++;
        end while (dev_rst && n < 2000);
    endtask

    task automatic power_on(input logic [1:0] mode, input logic pen, input logic [1:0] lvl);
        @(negedge clk_rc);
        por_pulse    = 1'b1;
        cfg_osc_mode = mode;
        cfg_pwrt_en  = pen;
        cfg_bor_lvl  = lvl;
        tick(3);
        por_pulse = 1'b0;
    endtask

    always @(posedge clk_rc) begin
        wd++;
        if (wd > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", wd, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic seen;

        // R1: state during the power-on pulse
        tick(2);
        check("R1 dev_rst in por", int'(dev_rst), 1);
        check("R1 stat_npor in por", int'(stat_npor), 0);
        check("R1 stat_bor in por", int'(stat_bor), 0);

        // Table of power-on scenarios: R2, R3, R7, R1
        for (int i = 0; i < NV; i++) begin
            power_on(VECS[i].mode, VECS[i].pwrt_en, VECS[i].lvl);
            wait_release(n);
            check_rng($sformatf("R2/R3 vec%0d release ticks", i), n, VECS[i].lo, VECS[i].hi);
            check($sformatf("R7 vec%0d level", i), int'(bor_lvl_sel), int'(VECS[i].lvl));
            check($sformatf("R1 vec%0d npor after por", i), int'(stat_npor), 0);
        end

        // Directed: RC mode, delay disabled for power-on
        power_on(OSC_RC, 1'b0, 2'd2);
        wait_release(n);
        check("R2 bypass release", n, 1);

        // R8: firmware sets npor
        fw_set_npor = 1'b1;
        tick(1);
        fw_set_npor = 1'b0;
        check("R8 npor set by firmware", int'(stat_npor), 1);

        // R4: dip one tick short of the filter window
        seen = 1'b0;
        bor_below = 1'b1;
        tick(F - 1);
        bor_below = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tick(1);
            if (dev_rst) seen = 1'b1;
        end
        check("R4 short dip no reset", int'(seen), 0);
        check("R8 short dip no flag", int'(stat_bor), 0);

        // R4/R5/R8: qualified brown-out held low
        bor_below = 1'b1;
        tick(F + 4);
        check("R4 long dip resets", int'(dev_rst), 1);
        check("R8 bor flag set", int'(stat_bor), 1);
        tick(10);
        check("R5 held while below", int'(dev_rst), 1);
        bor_below = 1'b0;
        wait_release(n);
        check_rng("R5 full delay after brown-out", n, P + 1, P + 5);
        check("R8 npor kept after brown-out", int'(stat_npor), 1);

        // R8: firmware clears bor flag
        fw_clr_bor = 1'b1;
        tick(1);
        fw_clr_bor = 1'b0;
        check("R8 bor flag cleared", int'(stat_bor), 0);

        // R6: second dip during the delay restarts it
        bor_below = 1'b1;
        tick(F + 4);
        bor_below = 1'b0;
        tick(10);
        check("R6 still in delay", int'(dev_rst), 1);
        bor_below = 1'b1;
        tick(F + 2);
        bor_below = 1'b0;
        wait_release(n);
        check_rng("R6 delay restarted", n, P + 1, P + 5);

        // R4: detection disabled
        cfg_bor_en = 1'b0;
        fw_clr_bor = 1'b1;
        tick(1);
        fw_clr_bor = 1'b0;
        seen = 1'b0;
        bor_below = 1'b1;
        for (int k = 0; k < 20; k++) begin
            tick(1);
            if (dev_rst) seen = 1'b1;
        end
        bor_below = 1'b0;
        check("R4 disabled no reset", int'(seen), 0);
        check("R4 disabled no flag", int'(stat_bor), 0);
        cfg_bor_en = 1'b1;
        tick(3);

        // R9: external pin
        mclr_n = 1'b0;
        #1;
        check("R9 immediate assert", int'(dev_rst), 1);
        tick(5);
        mclr_n = 1'b1;
        tick(1);
        check("R9 held one tick after release", int'(dev_rst), 1);
        tick(1);
        check("R9 released on second tick", int'(dev_rst), 0);

        // R10: wake in RC mode is ignored
        seen = 1'b0;
        wake_req = 1'b1;
        tick(1);
        wake_req = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (dev_rst) seen = 1'b1;
            tick(1);
        end
        check("R10 RC wake ignored", int'(seen), 0);

        // R10: wake in crystal mode runs the stabilisation count
        power_on(OSC_XT, 1'b0, 2'd0);
        wait_release(n);
        check_rng("R3 crystal bypass release", n, 1 + OST, 1 + OST + SLK);
        wake_req = 1'b1;
        tick(1);
        wake_req = 1'b0;
        check("R10 wake asserts reset", int'(dev_rst), 1);
        wait_release(n);
        check_rng("R10 wake release", n, OST - 1, OST + SLK);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule